// File: doc/BRIEF.md
# Streaming Phase-to-Phasor Lookup

This block takes a stream of phase words and returns, for each one, the complex unit phasor cos(2πx) + j·sin(2πx). The phase x is an unsigned fraction of a full turn. Only the twelve most significant phase bits are used. Their top two bits pick the quadrant. The other ten bits address a quarter-wave sine table that covers one quadrant, and the table is reflected and negated to cover the full circle. The table is built at elaboration time by a constant function, so no memory file is needed.

Both sides use AXI4-Stream-style valid/ready handshakes, and a last flag travels with each word. The pipeline has three stages and moves forward only when an input transfer is accepted. A stream that stops therefore leaves its final two results inside the block until more phase words are pushed in behind them. The usual way to use it is to feed it from a phase accumulator and pair its output with a sample stream for a complex mix.

Top module: `phasor_lookup`

## Requirements
- R1: Each output word holds the sine in bits [31:16] and the cosine in bits [15:0], both signed two's complement with 14 fractional bits, so 16'h3FFF is just below +1.0.
- R2: For phase word P, with p = P[23:12], the sine and cosine equal round(16384·sin(2πp/4096)) and round(16384·cos(2πp/4096)) within one LSB, in all four quadrants (P[23:22] = 0..3).
- R3: Values of magnitude 1.0 saturate to 16'h3FFF or 16'hC001. On the axes the outputs are exact: phase 24'h000000 gives 32'h00003FFF, 24'h400000 gives 32'h3FFF0000, 24'h800000 gives 32'h0000C001, and 24'hC00000 gives 32'hC0010000.
- R4: Phase bits [11:0] have no effect on the output.
- R5: The last flag given with a phase word comes out with that word's phasor.
- R6: The phasor for the k-th input transfer accepted after reset is output after transfer k+2 is accepted. It is visible in the cycle that follows that acceptance edge. The first two transfers after reset produce no output.
- R7: The pipeline moves only on accepted input transfers. Once the output word has been taken and no new input is accepted, the output valid stays low, and exactly two earlier words remain inside the block.
- R8: While an output word is valid but not accepted, input ready is low and the output data and last flag do not change.
- R9: Reset is synchronous and active low. While it is low, and for one cycle after its release, input ready is low. The first clock edge in reset clears the output valid.
- R10: No output component ever goes beyond ±16'h3FFF in magnitude (16'h8000 never appears).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset, held at least two cycles |
| phaseData | input | 24 | Phase word, unsigned fraction of a turn |
| phaseValid | input | 1 | Phase word valid |
| phaseLast | input | 1 | Last flag for the phase word |
| phaseReady | output | 1 | Block accepts the phase word |
| phasorData | output | 32 | {sine, cosine}, each signed with 14 fractional bits |
| phasorValid | output | 1 | Phasor word valid |
| phasorLast | output | 1 | Last flag that went in with the matching phase word |
| phasorReady | input | 1 | Downstream accepts the phasor word |

## Verification
The assertions assume that reset is held low for at least two clock edges and that the phase-side inputs are driven cleanly whenever reset is high. The hold and flow properties rely on the downstream ready being the only reason for a stall. The stimulus keeps to these assumptions: it holds reset for three edges, it changes every input one time unit after a rising edge, and it keeps a phase word and its valid steady until the word is accepted. Random ready gaps on the output side test the stall paths. Directed phases land on each axis, in each quadrant, and carry nonzero low bits.

// File: rtl/phasor_lookup_pkg.sv
package phasor_lookup_pkg;

  // Register stages between an accepted phase and a presented phasor.
  localparam int PIPE_DEPTH = 3;

  typedef enum logic [1:0] {
    QUAD_FIRST  = 2'd0,
    QUAD_SECOND = 2'd1,
    QUAD_THIRD  = 2'd2,
    QUAD_FOURTH = 2'd3
  } quadrant_e;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic advance;  // shift every stage by one
    logic clear;    // zero the stage registers
  } phasor_strobes_t;

endpackage

// File: rtl/phasor_quarter_rom.sv
module phasor_quarter_rom #(
  parameter int IDX_W  = 10,
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 14
) (
  input  logic [IDX_W:0]            addrA,
  input  logic [IDX_W:0]            addrB,
  output logic signed [OUT_W-1:0]   dataA,
  output logic signed [OUT_W-1:0]   dataB
);

  // One extra entry so that the quarter end point (1.0) is addressable.
  localparam int DEPTH = (1 << IDX_W) + 1;
  localparam longint PI_Q30 = 64'sd3373259426;
  localparam longint MAX_VAL = (longint'(1) <<< FRAC_W) - 1;

  // sin(pi*k / 2^(IDX_W+1)) as a Q30 Taylor series, rounded to FRAC_W bits.
  function automatic logic signed [OUT_W-1:0] sineEntry(input int k);
    longint x;
    longint term;
    longint acc;
    longint val;
    x    = (PI_Q30 * longint'(k)) >>> (IDX_W + 1);
    term = x;
    acc  = x;
    for (int n = 1; n <= 9; n++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -term / longint'((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    val = (acc * (longint'(1) <<< FRAC_W) + (longint'(1) <<< 29)) >>> 30;
    if (val > MAX_VAL) val = MAX_VAL;
    if (val < 0) val = 0;
    return val[OUT_W-1:0];
  endfunction

  logic signed [OUT_W-1:0] quarterTable [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : gen_entry
    localparam logic signed [OUT_W-1:0] ENTRY = sineEntry(g);
    assign quarterTable[g] = ENTRY;
  end

  assign dataA = quarterTable[addrA];
  assign dataB = quarterTable[addrB];

endmodule

// File: rtl/phasor_lookup_ctrl.sv
module phasor_lookup_ctrl
  import phasor_lookup_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic            outReady,
  output logic            inReady,
  output logic            outValid,
  output phasor_strobes_t strobes
);

  logic                  rstSeen;
  logic [PIPE_DEPTH-1:0] stageValid;
  logic                  resetActive;
  logic                  advance;
  logic                  retire;

  // Reset is stretched one cycle past the release of rstN.
  assign resetActive = !rstN || !rstSeen;
  assign outValid    = stageValid[PIPE_DEPTH-1];
  assign inReady     = !resetActive && (!outValid || outReady);
  assign advance     = inValid && inReady;
  assign retire      = outValid && outReady && !advance;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rstSeen    <= 1'b0;
      stageValid <= '0;
    end else begin
      rstSeen <= 1'b1;
      if (advance) begin
        stageValid <= {stageValid[PIPE_DEPTH-2:0], 1'b1};
      end else if (retire) begin
        stageValid[PIPE_DEPTH-1] <= 1'b0;
      end
    end
  end

  assign strobes.advance = advance;
  assign strobes.clear   = resetActive;

endmodule

// File: rtl/phasor_lookup_datapath.sv
module phasor_lookup_datapath
  import phasor_lookup_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OUT_W  = 16,
  parameter int FRAC_W = 14
) (
  input  logic                 clk,
  input  phasor_strobes_t      strobes,
  input  logic [ADDR_W-1:0]    topPhase,
  input  logic                 inLast,
  output logic [2*OUT_W-1:0]   outData,
  output logic                 outLast
);

  localparam int IDX_W = ADDR_W - 2;
  localparam logic [IDX_W:0] QUARTER_ADDR = {1'b1, {IDX_W{1'b0}}};

  // Stage 1: split phase into quadrant and in-quadrant index.
  quadrant_e         quad1;
  logic [IDX_W-1:0]  idx1;
  logic              last1;

  // Stage 2: raw table reads.
  quadrant_e               quad2;
  logic signed [OUT_W-1:0] sinA2;
  logic signed [OUT_W-1:0] cosA2;
  logic                    last2;

  // Stage 3: folded output.
  logic signed [OUT_W-1:0] sinOut;
  logic signed [OUT_W-1:0] cosOut;
  logic                    last3;

  logic [IDX_W:0]          addrSin;
  logic [IDX_W:0]          addrCos;
  logic signed [OUT_W-1:0] romSin;
  logic signed [OUT_W-1:0] romCos;
  logic signed [OUT_W-1:0] foldSin;
  logic signed [OUT_W-1:0] foldCos;

  assign addrSin = {1'b0, idx1};
  assign addrCos = QUARTER_ADDR - {1'b0, idx1};

  phasor_quarter_rom #(
    .IDX_W  (IDX_W),
    .OUT_W  (OUT_W),
    .FRAC_W (FRAC_W)
  ) rom_i (
    .addrA (addrSin),
    .addrB (addrCos),
    .dataA (romSin),
    .dataB (romCos)
  );

  always_comb begin
    unique case (quad2)
      QUAD_FIRST:  begin foldSin = sinA2;  foldCos = cosA2;  end
      QUAD_SECOND: begin foldSin = cosA2;  foldCos = -sinA2; end
      QUAD_THIRD:  begin foldSin = -sinA2; foldCos = -cosA2; end
      default:     begin foldSin = -cosA2; foldCos = sinA2;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      quad1  <= QUAD_FIRST;
      idx1   <= '0;
      last1  <= 1'b0;
      quad2  <= QUAD_FIRST;
      sinA2  <= '0;
      cosA2  <= '0;
      last2  <= 1'b0;
      sinOut <= '0;
      cosOut <= '0;
      last3  <= 1'b0;
    end else if (strobes.advance) begin
      quad1  <= quadrant_e'(topPhase[ADDR_W-1 -: 2]);
      idx1   <= topPhase[IDX_W-1:0];
      last1  <= inLast;
      quad2  <= quad1;
      sinA2  <= romSin;
      cosA2  <= romCos;
      last2  <= last1;
      sinOut <= foldSin;
      cosOut <= foldCos;
      last3  <= last2;
    end
  end

  assign outData = {sinOut, cosOut};
  assign outLast = last3;

endmodule

// File: rtl/phasor_lookup.sv
module phasor_lookup
  import phasor_lookup_pkg::*;
#(
  parameter int PHASE_W = 24,
  parameter int ADDR_W  = 12,
  parameter int OUT_W   = 16,
  parameter int FRAC_W  = 14
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PHASE_W-1:0]   phaseData,
  input  logic                 phaseValid,
  input  logic                 phaseLast,
  output logic                 phaseReady,
  output logic [2*OUT_W-1:0]   phasorData,
  output logic                 phasorValid,
  output logic                 phasorLast,
  input  logic                 phasorReady
);

  phasor_strobes_t     strobes;
  logic [ADDR_W-1:0]   topPhase;
  logic                unusedPhaseLsbs;

  assign topPhase        = phaseData[PHASE_W-1 -: ADDR_W];
  assign unusedPhaseLsbs = ^phaseData[PHASE_W-ADDR_W-1:0];

  phasor_lookup_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (phaseValid),
    .outReady (phasorReady),
    .inReady  (phaseReady),
    .outValid (phasorValid),
    .strobes  (strobes)
  );

  phasor_lookup_datapath #(
    .ADDR_W (ADDR_W),
    .OUT_W  (OUT_W),
    .FRAC_W (FRAC_W)
  ) datapath_i (
    .clk      (clk),
    .strobes  (strobes),
    .topPhase (topPhase),
    .inLast   (phaseLast),
    .outData  (phasorData),
    .outLast  (phasorLast)
  );

endmodule

// File: rtl/phasor_lookup_checker.sv
module phasor_lookup_checker #(
  parameter int PHASE_W = 24,
  parameter int OUT_W   = 16,
  parameter int FRAC_W  = 14
) (
  input logic               clk,
  input logic               rstN,
  input logic [PHASE_W-1:0] phaseData,
  input logic               phaseValid,
  input logic               phaseLast,
  input logic               phaseReady,
  input logic [2*OUT_W-1:0] phasorData,
  input logic               phasorValid,
  input logic               phasorLast,
  input logic               phasorReady
);

  localparam logic signed [OUT_W-1:0] POS_FULL = OUT_W'((1 << FRAC_W) - 1);
  localparam logic signed [OUT_W-1:0] NEG_FULL = -POS_FULL;

  logic signed [OUT_W-1:0] sinPart;
  logic signed [OUT_W-1:0] cosPart;
  assign sinPart = phasorData[2*OUT_W-1:OUT_W];
  assign cosPart = phasorData[OUT_W-1:0];

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    phasorValid && !phasorReady |=>
      phasorValid && $stable(phasorData) && $stable(phasorLast));

  a_r8_input_blocked: assert property (@(posedge clk) disable iff (!rstN)
    phasorValid && !phasorReady |-> !phaseReady);

  a_r9_reset_clears: assert property (@(posedge clk)
    !rstN |=> !phasorValid && !phaseReady);

  a_r7_rise_needs_input: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phasorValid) |-> $past(phaseValid && phaseReady));

  a_r7_idle_after_take: assert property (@(posedge clk) disable iff (!rstN)
    phasorValid && phasorReady && !(phaseValid && phaseReady) |=> !phasorValid);

  a_r10_magnitude: assert property (@(posedge clk) disable iff (!rstN)
    phasorValid |-> (sinPart <= POS_FULL) && (sinPart >= NEG_FULL) &&
                    (cosPart <= POS_FULL) && (cosPart >= NEG_FULL));

endmodule

bind phasor_lookup phasor_lookup_checker #(
  .PHASE_W (PHASE_W),
  .OUT_W   (OUT_W),
  .FRAC_W  (FRAC_W)
) checker_i (
  .clk         (clk),
  .rstN        (rstN),
  .phaseData   (phaseData),
  .phaseValid  (phaseValid),
  .phaseLast   (phaseLast),
  .phaseReady  (phaseReady),
  .phasorData  (phasorData),
  .phasorValid (phasorValid),
  .phasorLast  (phasorLast),
  .phasorReady (phasorReady)
);

// File: tb/phasor_lookup_tb_top.sv
`timescale 1ns/1ps
module phasor_lookup_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] phaseData = '0;
  logic        phaseValid = 1'b0;
  logic        phaseLast = 1'b0;
  logic        phaseReady;
  logic [31:0] phasorData;
  logic        phasorValid;
  logic        phasorLast;
  logic        phasorReady = 1'b0;

  int checks = 0;
  int errors = 0;
  bit streamDone = 1'b0;

  typedef struct {
    logic [23:0] ph;
    logic        last;
  } sent_t;
  sent_t sentQ[$];

  always #2 clk = ~clk;

  phasor_lookup dut_i (
    .clk         (clk),
    .rstN        (rstN),
    .phaseData   (phaseData),
    .phaseValid  (phaseValid),
    .phaseLast   (phaseLast),
    .phaseReady  (phaseReady),
    .phasorData  (phasorData),
    .phasorValid (phasorValid),
    .phasorLast  (phasorLast),
    .phasorReady (phasorReady)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int refSine(input int p);
    real r;
    int  v;
    r = $sin(2.0 * 3.14159265358979 * real'(p) / 4096.0) * 16384.0;
    v = int'(r);
    if (v > 16383) v = 16383;
    if (v < -16383) v = -16383;
    return v;
  endfunction

  function automatic int absDiff(input int a, input int b);
    return (a > b) ? a - b : b - a;
  endfunction

  // Scoreboard: inputs accepted in order; each output compared to the oldest.
  always @(negedge clk) begin
    if (rstN) begin
      if (phaseValid && phaseReady) sentQ.push_back('{phaseData, phaseLast});
      if (phasorValid && phasorReady) begin
        if (sentQ.size() == 0) begin
          chk(1'b0, "R6 output without pending input", 1, 0);
        end else begin
          sent_t it;
          int p, es, ec, as, ac, tol;
          it  = sentQ.pop_front();
          p   = int'(it.ph[23:12]);
          es  = refSine(p);
          ec  = refSine((p + 1024) % 4096);
          as  = int'($signed(phasorData[31:16]));
          ac  = int'($signed(phasorData[15:0]));
          tol = (it.ph[21:12] == 10'd0) ? 0 : 1;
          if (tol == 0) begin
            chk(as == es, "R3 axis sine", as, es);
            chk(ac == ec, "R3 axis cosine", ac, ec);
          end else if (it.ph[11:0] != 12'd0) begin
            chk(absDiff(as, es) <= tol, "R4 sine with low bits set", as, es);
            chk(absDiff(ac, ec) <= tol, "R4 cosine with low bits set", ac, ec);
          end else begin
            chk(absDiff(as, es) <= tol, "R2 sine value", as, es);
            chk(absDiff(ac, ec) <= tol, "R1 cosine in low half", ac, ec);
          end
          chk(phasorLast == it.last, "R5 last flag", int'(phasorLast), int'(it.last));
        end
      end
    end
  end

  // Leaves phaseValid high, returns one time unit after the accepting edge.
  task automatic sendItem(input logic [23:0] ph, input logic last);
    phaseData  = ph;
    phaseLast  = last;
    phaseValid = 1'b1;
    do @(negedge clk); while (!phaseReady);
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    phaseValid = 1'b0;
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic testReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!phaseReady, "R9 ready low in reset", int'(phaseReady), 0);
    chk(!phasorValid, "R9 valid low in reset", int'(phasorValid), 0);
    @(posedge clk);
    #1;
    rstN = 1'b1;
    @(negedge clk);
    chk(!phaseReady, "R9 ready low one cycle after release", int'(phaseReady), 0);
    @(posedge clk);
    #1;
    @(negedge clk);
    chk(phaseReady, "R9 ready high after stretch", int'(phaseReady), 1);
    @(posedge clk);
    #1;
  endtask

  task automatic testFillLatency();
    phasorReady = 1'b1;
    sendItem(24'h000000, 1'b1);
    phaseValid = 1'b0;
    @(negedge clk);
    chk(!phasorValid, "R6 no output after first transfer", int'(phasorValid), 0);
    @(posedge clk); #1;
    sendItem(24'h400000, 1'b0);
    phaseValid = 1'b0;
    @(negedge clk);
    chk(!phasorValid, "R6 no output after second transfer", int'(phasorValid), 0);
    @(posedge clk); #1;
    sendItem(24'h800000, 1'b0);
    phaseValid = 1'b0;
    @(negedge clk);
    chk(phasorValid, "R6 output after third transfer", int'(phasorValid), 1);
    chk(phasorData == 32'h00003FFF, "R3 phase zero word", int'(phasorData), 32'h00003FFF);
    @(posedge clk); #1;
    idle(4);
    @(negedge clk);
    chk(!phasorValid, "R7 output stays idle without input", int'(phasorValid), 0);
    chk(sentQ.size() == 2, "R7 two words held inside", sentQ.size(), 2);
    @(posedge clk); #1;
    sendItem(24'hC00000, 1'b1);
    phaseValid = 1'b0;
    @(negedge clk);
    chk(phasorData == 32'h3FFF0000, "R3 quarter-turn word", int'(phasorData), 32'h3FFF0000);
    @(posedge clk); #1;
    sendItem(24'h2AB123, 1'b0);
    phaseValid = 1'b0;
    @(negedge clk);
    chk(phasorData == 32'h0000C001, "R3 half-turn word", int'(phasorData), 32'h0000C001);
    @(posedge clk); #1;
    sendItem(24'h2AB000, 1'b0);
    phaseValid = 1'b0;
    @(negedge clk);
    chk(phasorData == 32'hC0010000, "R3 three-quarter word", int'(phasorData), 32'hC0010000);
    chk(phasorLast == 1'b1, "R5 last flag on three-quarter word", int'(phasorLast), 1);
    @(posedge clk); #1;
  endtask

  task automatic testLowBits();
    phasorReady = 1'b1;
    sendItem(24'h2ABFFF, 1'b0);
    sendItem(24'h9C5801, 1'b1);
    sendItem(24'h9C5000, 1'b0);
    sendItem(24'hF3E7A5, 1'b0);
    phaseValid = 1'b0;
    @(negedge clk);
    chk(phasorValid, "R4 word with low bits emerges", int'(phasorValid), 1);
    @(posedge clk); #1;
  endtask

  task automatic testBackpressure();
    logic [31:0] held;
    logic        heldLast;
    phasorReady = 1'b0;
    sendItem(24'h5A0000, 1'b1);
    phaseData = 24'h6B0000;
    phaseLast = 1'b0;
    @(negedge clk);
    chk(phasorValid, "R8 output valid while stalled", int'(phasorValid), 1);
    chk(!phaseReady, "R8 input blocked while stalled", int'(phaseReady), 0);
    held     = phasorData;
    heldLast = phasorLast;
    repeat (4) begin
      @(posedge clk); #1;
      @(negedge clk);
      chk(phasorData == held, "R8 data held", int'(phasorData), int'(held));
      chk(phasorLast == heldLast, "R8 last held", int'(phasorLast), int'(heldLast));
      chk(!phaseReady, "R8 ready stays low", int'(phaseReady), 0);
    end
    @(posedge clk); #1;
    phasorReady = 1'b1;
    @(negedge clk);
    chk(phaseReady, "R8 ready returns when output taken", int'(phaseReady), 1);
    @(posedge clk); #1;
    phaseValid = 1'b0;
  endtask

  task automatic testStream();
    streamDone = 1'b0;
    fork
      begin
        for (int i = 0; i < 300; i++) begin
          sendItem(24'($urandom), 1'(($urandom % 7) == 0));
        end
        phaseValid = 1'b0;
        streamDone = 1'b1;
      end
      begin
        while (!streamDone) begin
          @(posedge clk); #1;
          phasorReady = 1'(($urandom % 4) != 0);
        end
      end
    join
    phasorReady = 1'b1;
    idle(3);
    @(negedge clk);
    chk(!phasorValid, "R7 drained output idle after stream", int'(phasorValid), 0);
    chk(sentQ.size() == 2, "R7 two stream words still inside", sentQ.size(), 2);
    @(posedge clk); #1;
    sendItem(24'h111000, 1'b0);
    sendItem(24'hEEE000, 1'b1);
    phaseValid = 1'b0;
    idle(2);
    chk(sentQ.size() == 2, "R7 flush pushed out stream tail", sentQ.size(), 2);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    testReset();
    testFillLatency();
    testLowBits();
    testBackpressure();
    testStream();
    finishRun();
  end

endmodule